// File: doc/BRIEF.md
# Multi-Program Page Table Translator

This block turns a 32-bit virtual address into a 20-bit physical address for one of several resident programs. Every program owns a private single-level page table held in flops inside the block. A request carries a program identifier, the virtual address and a write flag. The block splits the address into a page offset (the low 12 bits, because pages are 4 KB) and a virtual page number. It uses the low bits of the page number to pick a table entry. One cycle later it answers either with the entry's frame number joined to the unchanged offset, or with a fault.

Each entry holds a valid flag, a modified ("dirty") flag and an 8-bit frame number. A write that translates successfully marks its entry modified. An operating system installs, replaces or removes mappings through a separate update port that writes one whole entry of one program per cycle. Reset empties every table, so every access faults until mappings are installed.

Top module: `pgtbl_xlate`

## Requirements
- R1: On a successful translation, `rsp_pa` equals the 8-bit frame number of the selected entry in bits 19:12, followed by virtual address bits 11:0 unchanged in bits 11:0.
- R2: A request whose selected entry has its valid flag clear responds with `rsp_fault`=1, and `rsp_pa` and `rsp_dirty` are both 0.
- R3: A request with any of virtual address bits 31:16 set faults, whatever the table holds. The entry index is taken from bits 15:12.
- R4: Each value of `req_pid` (0 to 3) selects its own 16-entry table. The same virtual address under two identifiers translates through two independent entries.
- R5: Any virtual page may map to any frame. Two programs may map different page numbers to the same frame, and both translate to it.
- R6: A write request (`req_wr`=1) that does not fault sets the entry's dirty flag. `rsp_dirty` reports the entry's dirty flag as it stands after the access. A read leaves the flag unchanged, and a faulting write does not change it.
- R7: An update (`upd_en`=1) overwrites the addressed entry with `upd_valid`, `upd_dirty` and `upd_frame`. Rewriting an entry with `upd_dirty`=0 clears its dirty flag, and writing `upd_valid`=0 removes the mapping.
- R8: `rsp_done` is high for exactly the cycle after each cycle in which `req_vld` is high, and low otherwise. While `rsp_done` is low, `rsp_fault`, `rsp_pa` and `rsp_dirty` are 0.
- R9: After reset, every entry of every program is invalid, so every request faults.
- R10: A request and an update in the same cycle are both handled. The request is answered from the contents before the update. If both touch the same entry, the update's dirty value is the one that is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Translation request strobe |
| req_pid | input | 2 | Program identifier of the request |
| req_va | input | 32 | Virtual address |
| req_wr | input | 1 | Request is a store |
| upd_en | input | 1 | Table entry write strobe |
| upd_pid | input | 2 | Program whose table is written |
| upd_idx | input | 4 | Entry index within that table |
| upd_valid | input | 1 | New valid flag |
| upd_dirty | input | 1 | New dirty flag |
| upd_frame | input | 8 | New frame number |
| rsp_done | output | 1 | Response pulse, one cycle after a request |
| rsp_fault | output | 1 | Page fault for the answered request |
| rsp_pa | output | 20 | Physical address, zero on a fault |
| rsp_dirty | output | 1 | Dirty flag of the entry after the access |

## Verification
The hardest case to reach from the ports is a request and an update that land on the same entry in the same clock. That is where the ordering between the old contents, the write-set of the dirty flag and the overwrite is decided. The bench drives both strobes on one falling edge, first for a read and then for a store. It checks the response against the old mapping. It then checks the surviving entry with a follow-up read. A second subtle case is a store that faults only because of its high page-number bits while its low index bits select a valid entry. A later read of that entry shows that its dirty flag was left alone.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

   // Outcome of a single lookup, decided in the request cycle.
   typedef enum logic [1:0] {
      PGX_HIT        = 2'd0,
      PGX_NOT_MAPPED = 2'd1,
      PGX_OUT_RANGE  = 2'd2
   } pgx_cause_e;

endpackage

// File: rtl/pgx_va_split.sv
module pgx_va_split #(
   parameter int VA_W  = 32,
   parameter int OFS_W = 12,
   parameter int IDX_W = 4
) (
   input  logic [VA_W-1:0]  va,
   output logic [OFS_W-1:0] ofs,
   output logic [IDX_W-1:0] idx,
   output logic             in_range
);

   localparam int HI_LSB = OFS_W + IDX_W;

   assign ofs = va[OFS_W-1:0];
   assign idx = va[OFS_W +: IDX_W];

   generate
      if (HI_LSB < VA_W) begin : g_hi_check
         // Page-number bits above the table index must be zero.
         assign in_range = ~(|va[VA_W-1:HI_LSB]);
      end else begin : g_hi_none
         assign in_range = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/pgx_table.sv
module pgx_table #(
   parameter int PROG_N  = 4,
   parameter int IDX_N   = 16,
   parameter int FRAME_W = 8,
   localparam int PID_W  = (PROG_N > 1) ? $clog2(PROG_N) : 1,
   localparam int IDX_W  = (IDX_N > 1) ? $clog2(IDX_N) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   // lookup
   input  logic [PID_W-1:0]   rd_pid,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic               rd_valid,
   output logic               rd_dirty,
   output logic [FRAME_W-1:0] rd_frame,
   // hardware dirty set
   input  logic               set_en,
   input  logic [PID_W-1:0]   set_pid,
   input  logic [IDX_W-1:0]   set_idx,
   // full-entry write
   input  logic               upd_en,
   input  logic [PID_W-1:0]   upd_pid,
   input  logic [IDX_W-1:0]   upd_idx,
   input  logic               upd_valid,
   input  logic               upd_dirty,
   input  logic [FRAME_W-1:0] upd_frame
);

   logic [PROG_N-1:0]  prog_valid;
   logic [PROG_N-1:0]  prog_dirty;
   logic [FRAME_W-1:0] prog_frame [PROG_N];

   generate
      for (genvar p = 0; p < PROG_N; p++) begin : g_prog
         logic [IDX_N-1:0]   valid_q;
         logic [IDX_N-1:0]   dirty_q;
         logic [FRAME_W-1:0] frame_q [IDX_N];
         logic               upd_here;
         logic               set_here;

         assign upd_here = upd_en && (upd_pid == PID_W'(p));
         assign set_here = set_en && (set_pid == PID_W'(p));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid_q <= '0;
               dirty_q <= '0;
               for (int i = 0; i < IDX_N; i++) frame_q[i] <= '0;
            end else begin
               for (int i = 0; i < IDX_N; i++) begin
                  // A full-entry write outranks the hardware dirty set.
                  if (upd_here && (upd_idx == IDX_W'(i))) begin
                     valid_q[i] <= upd_valid;
                     dirty_q[i] <= upd_dirty;
                     frame_q[i] <= upd_frame;
                  end else if (set_here && (set_idx == IDX_W'(i))) begin
                     dirty_q[i] <= 1'b1;
                  end
               end
            end
         end

         assign prog_valid[p] = valid_q[rd_idx];
         assign prog_dirty[p] = dirty_q[rd_idx];
         assign prog_frame[p] = frame_q[rd_idx];
      end
   endgenerate

   // Program select; an identifier with no table reads as invalid.
   always_comb begin
      rd_valid = 1'b0;
      rd_dirty = 1'b0;
      rd_frame = '0;
      for (int p = 0; p < PROG_N; p++) begin
         if (rd_pid == PID_W'(p)) begin
            rd_valid = prog_valid[p];
            rd_dirty = prog_dirty[p];
            rd_frame = prog_frame[p];
         end
      end
   end

endmodule

// File: rtl/pgx_resp.sv
module pgx_resp
   import pgx_pkg::*;
#(
   parameter int FRAME_W = 8,
   parameter int OFS_W   = 12,
   localparam int PA_W   = FRAME_W + OFS_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_vld,
   input  pgx_cause_e         cause,
   input  logic [FRAME_W-1:0] frame,
   input  logic [OFS_W-1:0]   ofs,
   input  logic               dirty_after,
   output logic               rsp_done,
   output logic               rsp_fault,
   output logic [PA_W-1:0]    rsp_pa,
   output logic               rsp_dirty
);

   logic            fault_d;
   logic [PA_W-1:0] pa_d;
   logic            dirty_d;

   always_comb begin
      fault_d = 1'b0;
      pa_d    = '0;
      dirty_d = 1'b0;
      if (req_vld) begin
         unique case (cause)
            PGX_HIT: begin
               pa_d    = {frame, ofs};
               dirty_d = dirty_after;
            end
            PGX_NOT_MAPPED,
            PGX_OUT_RANGE: fault_d = 1'b1;
            default:       fault_d = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_done  <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_pa    <= '0;
         rsp_dirty <= 1'b0;
      end else begin
         rsp_done  <= req_vld;
         rsp_fault <= fault_d;
         rsp_pa    <= pa_d;
         rsp_dirty <= dirty_d;
      end
   end

endmodule

// File: rtl/pgtbl_xlate.sv
module pgtbl_xlate
   import pgx_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int OFS_W   = 12,
   parameter int PROG_N  = 4,
   parameter int IDX_N   = 16,
   parameter int FRAME_W = 8,
   localparam int PID_W  = (PROG_N > 1) ? $clog2(PROG_N) : 1,
   localparam int IDX_W  = (IDX_N > 1) ? $clog2(IDX_N) : 1,
   localparam int PA_W   = FRAME_W + OFS_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_vld,
   input  logic [PID_W-1:0]   req_pid,
   input  logic [VA_W-1:0]    req_va,
   input  logic               req_wr,
   input  logic               upd_en,
   input  logic [PID_W-1:0]   upd_pid,
   input  logic [IDX_W-1:0]   upd_idx,
   input  logic               upd_valid,
   input  logic               upd_dirty,
   input  logic [FRAME_W-1:0] upd_frame,
   output logic               rsp_done,
   output logic               rsp_fault,
   output logic [PA_W-1:0]    rsp_pa,
   output logic               rsp_dirty
);

   // Elaboration-time parameter checks.
   generate
      if (OFS_W < 1 || OFS_W + IDX_W > VA_W) begin : g_bad_split
         $error("pgtbl_xlate: offset plus index width exceeds the address");
      end
      if (PROG_N < 1 || IDX_N < 2) begin : g_bad_count
         $error("pgtbl_xlate: need at least one program and two entries");
      end
      if ((1 << IDX_W) != IDX_N) begin : g_bad_depth
         $error("pgtbl_xlate: table depth must be a power of two");
      end
      if (FRAME_W < 1) begin : g_bad_frame
         $error("pgtbl_xlate: frame width must be positive");
      end
   endgenerate

   logic [OFS_W-1:0]   va_ofs;
   logic [IDX_W-1:0]   va_idx;
   logic               va_in_range;
   logic               ent_valid;
   logic               ent_dirty;
   logic [FRAME_W-1:0] ent_frame;
   pgx_cause_e         cause;
   logic               wr_hit;

   pgx_va_split #(
      .VA_W  (VA_W),
      .OFS_W (OFS_W),
      .IDX_W (IDX_W)
   ) u_split (
      .va       (req_va),
      .ofs      (va_ofs),
      .idx      (va_idx),
      .in_range (va_in_range)
   );

   always_comb begin
      if (!va_in_range)    cause = PGX_OUT_RANGE;
      else if (!ent_valid) cause = PGX_NOT_MAPPED;
      else                 cause = PGX_HIT;
   end

   assign wr_hit = req_vld && req_wr && (cause == PGX_HIT);

   pgx_table #(
      .PROG_N  (PROG_N),
      .IDX_N   (IDX_N),
      .FRAME_W (FRAME_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_pid    (req_pid),
      .rd_idx    (va_idx),
      .rd_valid  (ent_valid),
      .rd_dirty  (ent_dirty),
      .rd_frame  (ent_frame),
      .set_en    (wr_hit),
      .set_pid   (req_pid),
      .set_idx   (va_idx),
      .upd_en    (upd_en),
      .upd_pid   (upd_pid),
      .upd_idx   (upd_idx),
      .upd_valid (upd_valid),
      .upd_dirty (upd_dirty),
      .upd_frame (upd_frame)
   );

   pgx_resp #(
      .FRAME_W (FRAME_W),
      .OFS_W   (OFS_W)
   ) u_resp (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_vld     (req_vld),
      .cause       (cause),
      .frame       (ent_frame),
      .ofs         (va_ofs),
      .dirty_after (ent_dirty | req_wr),
      .rsp_done    (rsp_done),
      .rsp_fault   (rsp_fault),
      .rsp_pa      (rsp_pa),
      .rsp_dirty   (rsp_dirty)
   );

endmodule

// File: rtl/pgx_chk.sv
module pgx_chk #(
   parameter int VA_W    = 32,
   parameter int OFS_W   = 12,
   parameter int IDX_W   = 4,
   parameter int PA_W    = 20
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_vld,
   input logic [VA_W-1:0] req_va,
   input logic            req_wr,
   input logic            rsp_done,
   input logic            rsp_fault,
   input logic [PA_W-1:0] rsp_pa,
   input logic            rsp_dirty
);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_done);

   assert_no_stray_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !rsp_done);

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_done |-> (!rsp_fault && rsp_pa == '0 && !rsp_dirty));

   assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> (rsp_fault || rsp_pa[OFS_W-1:0] == $past(req_va[OFS_W-1:0])));

   assert_fault_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_fault) |-> (rsp_pa == '0 && !rsp_dirty));

   assert_write_hit_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_wr) |=> (rsp_fault || rsp_dirty));

   generate
      if (OFS_W + IDX_W < VA_W) begin : g_hi
         assert_high_vpn_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (req_vld && (|req_va[VA_W-1:OFS_W+IDX_W])) |=> rsp_fault);
      end
   endgenerate

endmodule

bind pgtbl_xlate pgx_chk #(
   .VA_W  (VA_W),
   .OFS_W (OFS_W),
   .IDX_W (IDX_W),
   .PA_W  (PA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_vld   (req_vld),
   .req_va    (req_va),
   .req_wr    (req_wr),
   .rsp_done  (rsp_done),
   .rsp_fault (rsp_fault),
   .rsp_pa    (rsp_pa),
   .rsp_dirty (rsp_dirty)
);

// File: tb/sim_pgtbl_xlate.sv
module sim_pgtbl_xlate;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic [1:0]  req_pid = '0;
   logic [31:0] req_va = '0;
   logic        req_wr = 1'b0;
   logic        upd_en = 1'b0;
   logic [1:0]  upd_pid = '0;
   logic [3:0]  upd_idx = '0;
   logic        upd_valid = 1'b0;
   logic        upd_dirty = 1'b0;
   logic [7:0]  upd_frame = '0;
   logic        rsp_done;
   logic        rsp_fault;
   logic [19:0] rsp_pa;
   logic        rsp_dirty;

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   pgtbl_xlate u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_vld   (req_vld),
      .req_pid   (req_pid),
      .req_va    (req_va),
      .req_wr    (req_wr),
      .upd_en    (upd_en),
      .upd_pid   (upd_pid),
      .upd_idx   (upd_idx),
      .upd_valid (upd_valid),
      .upd_dirty (upd_dirty),
      .upd_frame (upd_frame),
      .rsp_done  (rsp_done),
      .rsp_fault (rsp_fault),
      .rsp_pa    (rsp_pa),
      .rsp_dirty (rsp_dirty)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Compare a full response: done, fault, address, dirty.
   task automatic expect_rsp(input string tag, input bit flt, input logic [19:0] pa,
                             input bit drt);
      logic [22:0] act;
      logic [22:0] exp;
      act = {rsp_done, rsp_fault, rsp_pa, rsp_dirty};
      exp = {1'b1, flt, pa, drt};
      check(act == exp, tag, 32'(act), 32'(exp));
   endtask

   task automatic install(input logic [1:0] pid, input logic [3:0] idx, input bit v,
                          input bit d, input logic [7:0] fr);
      @(negedge clk);
      upd_en = 1'b1; upd_pid = pid; upd_idx = idx;
      upd_valid = v; upd_dirty = d; upd_frame = fr;
      @(negedge clk);
      upd_en = 1'b0;
   endtask

   // Issue one request; response is sampled on the next falling edge.
   task automatic access(input logic [1:0] pid, input logic [31:0] va, input bit wr);
      @(negedge clk);
      req_vld = 1'b1; req_pid = pid; req_va = va; req_wr = wr;
      @(negedge clk);
      req_vld = 1'b0; req_wr = 1'b0;
   endtask

   task automatic t_reset;
      check(rsp_done == 1'b0, "R8 idle after reset", 32'(rsp_done), 32'd0);
      access(2'd0, 32'h0000_0000, 1'b0);
      expect_rsp("R9 empty table pid0 faults", 1'b1, 20'h0, 1'b0);
      access(2'd3, 32'h0000_F123, 1'b1);
      expect_rsp("R9 empty table pid3 write faults", 1'b1, 20'h0, 1'b0);
   endtask

   task automatic t_translate;
      install(2'd0, 4'd3, 1'b1, 1'b0, 8'hA5);
      access(2'd0, 32'h0000_3ABC, 1'b0);
      expect_rsp("R1 frame and offset", 1'b0, 20'hA5ABC, 1'b0);
      access(2'd0, 32'h0000_3FFF, 1'b0);
      expect_rsp("R1 top offset", 1'b0, 20'hA5FFF, 1'b0);
      access(2'd0, 32'h0000_4000, 1'b0);
      expect_rsp("R2 neighbour entry unmapped", 1'b1, 20'h0, 1'b0);
   endtask

   task automatic t_per_program;
      install(2'd1, 4'd3, 1'b1, 1'b0, 8'h11);
      access(2'd1, 32'h0000_3ABC, 1'b0);
      expect_rsp("R4 pid1 own table", 1'b0, 20'h11ABC, 1'b0);
      access(2'd0, 32'h0000_3ABC, 1'b0);
      expect_rsp("R4 pid0 unchanged", 1'b0, 20'hA5ABC, 1'b0);
      access(2'd2, 32'h0000_3ABC, 1'b0);
      expect_rsp("R4 pid2 unmapped", 1'b1, 20'h0, 1'b0);
   endtask

   task automatic t_shared_frame;
      install(2'd2, 4'd7, 1'b1, 1'b0, 8'hA5);
      access(2'd2, 32'h0000_7123, 1'b0);
      expect_rsp("R5 pid2 page7 shares frame A5", 1'b0, 20'hA5123, 1'b0);
      access(2'd0, 32'h0000_3123, 1'b0);
      expect_rsp("R5 pid0 page3 same frame", 1'b0, 20'hA5123, 1'b0);
   endtask

   task automatic t_range;
      access(2'd0, 32'h0001_3ABC, 1'b0);
      expect_rsp("R3 bit16 set faults", 1'b1, 20'h0, 1'b0);
      access(2'd0, 32'h8000_3000, 1'b0);
      expect_rsp("R3 bit31 set faults", 1'b1, 20'h0, 1'b0);
   endtask

   task automatic t_dirty;
      access(2'd0, 32'h0000_3010, 1'b0);
      expect_rsp("R6 read leaves clean", 1'b0, 20'hA5010, 1'b0);
      access(2'd0, 32'h0000_3020, 1'b1);
      expect_rsp("R6 write hit sets dirty", 1'b0, 20'hA5020, 1'b1);
      access(2'd0, 32'h0000_3030, 1'b0);
      expect_rsp("R6 dirty held on read", 1'b0, 20'hA5030, 1'b1);
      // Faulting store whose low index bits select a valid entry.
      access(2'd1, 32'h1000_3040, 1'b1);
      expect_rsp("R6 out-of-range write faults", 1'b1, 20'h0, 1'b0);
      access(2'd1, 32'h0000_3040, 1'b0);
      expect_rsp("R6 faulting write left entry clean", 1'b0, 20'h11040, 1'b0);
   endtask

   task automatic t_update;
      install(2'd0, 4'd3, 1'b1, 1'b0, 8'h5C);
      access(2'd0, 32'h0000_3001, 1'b0);
      expect_rsp("R7 rewrite clears dirty", 1'b0, 20'h5C001, 1'b0);
      install(2'd0, 4'd3, 1'b1, 1'b1, 8'h5C);
      access(2'd0, 32'h0000_3002, 1'b0);
      expect_rsp("R7 explicit dirty kept", 1'b0, 20'h5C002, 1'b1);
      install(2'd0, 4'd3, 1'b0, 1'b0, 8'h5C);
      access(2'd0, 32'h0000_3003, 1'b0);
      expect_rsp("R7 invalidate removes mapping", 1'b1, 20'h0, 1'b0);
   endtask

   task automatic t_timing;
      @(negedge clk);
      req_vld = 1'b1; req_pid = 2'd1; req_va = 32'h0000_3100; req_wr = 1'b0;
      @(negedge clk);
      expect_rsp("R8 first of back-to-back", 1'b0, 20'h11100, 1'b0);
      req_va = 32'h0000_3200;
      @(negedge clk);
      req_vld = 1'b0;
      expect_rsp("R8 second of back-to-back", 1'b0, 20'h11200, 1'b0);
      @(negedge clk);
      check({rsp_done, rsp_fault, rsp_pa, rsp_dirty} == '0, "R8 done drops and outputs clear",
            32'({rsp_done, rsp_fault, rsp_pa, rsp_dirty}), 32'd0);
   endtask

   task automatic t_collision;
      // Read and remap of the same entry together: old mapping answers.
      @(negedge clk);
      req_vld = 1'b1; req_pid = 2'd1; req_va = 32'h0000_3300; req_wr = 1'b0;
      upd_en = 1'b1; upd_pid = 2'd1; upd_idx = 4'd3;
      upd_valid = 1'b1; upd_dirty = 1'b0; upd_frame = 8'h22;
      @(negedge clk);
      req_vld = 1'b0; upd_en = 1'b0;
      expect_rsp("R10 read sees old mapping", 1'b0, 20'h11300, 1'b0);
      access(2'd1, 32'h0000_3400, 1'b0);
      expect_rsp("R10 update took effect", 1'b0, 20'h22400, 1'b0);
      // Store and clean rewrite of the same entry together: rewrite wins.
      @(negedge clk);
      req_vld = 1'b1; req_pid = 2'd1; req_va = 32'h0000_3500; req_wr = 1'b1;
      upd_en = 1'b1; upd_pid = 2'd1; upd_idx = 4'd3;
      upd_valid = 1'b1; upd_dirty = 1'b0; upd_frame = 8'h33;
      @(negedge clk);
      req_vld = 1'b0; req_wr = 1'b0; upd_en = 1'b0;
      expect_rsp("R10 store answered from old entry", 1'b0, 20'h22500, 1'b1);
      access(2'd1, 32'h0000_3600, 1'b0);
      expect_rsp("R10 update dirty value kept", 1'b0, 20'h33600, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_translate();
      t_per_program();
      t_shared_frame();
      t_range();
      t_dirty();
      t_update();
      t_timing();
      t_collision();
      repeat (2) @(negedge clk);
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

endmodule